// File: doc/BRIEF.md
# Transceiver Diagnostic Register Bank

This block is the diagnostic page of a pluggable optical module's management memory, reached by a host through a synchronous byte-wide read/write port. One 256-byte offset space holds alarm and warning thresholds, a calibration area protected by a running checksum byte, snapshots of five real-time measurement words, one status/control byte and a user scratch area. Threshold and calibration bytes are loaded through a separate initialization port. Measurement words arrive from the datapath with a valid strobe.

Five asynchronous module pins are brought into the clock domain through two-flop synchronizers. They are sampled into the status byte at a configurable period, so that a pin change shows up within a bounded time. Two host-writable soft bits are ORed with their hardware pins to form the effective laser-off and full-rate outputs. A not-ready flag is held from reset until the first measurement set has been captured.

Multi-byte values are read most-significant byte first. Reading the high byte of a pair latches its low byte, so a host that reads the two bytes back to back always gets both halves of the same sample.

Top module: `xdiag_bank`

## Requirements
- R1: After reset, offset 110 reads 0x01 with all pins low. Offsets 95 and 96..105 read 0x00. Both soft bits are clear, and `not_ready` is 1.
- R2: An initialization write to offset 0..94 stores the byte, and a host read of that offset returns it. Read data appears on `host_rdata` on the clock edge that samples `host_rd` and holds until the next read. Offsets 0..39 hold 2-byte big-endian threshold pairs. Quantities run temperature, supply, bias, TX power, RX power, and each has high alarm, low alarm, high warning, low warning.
- R3: Offset 95 reads the low 8 bits of the sum of bytes 0..94. It is updated on the edge of each initialization write and holds otherwise.
- R4: On `meas_valid` the five words on `meas_words` are captured, word k taken from bits [16k+15:16k]. They are then readable big-endian at offsets 96+2k (high byte) and 97+2k (low byte).
- R5: A read of an even offset in 0..38 or 96..104 latches the byte at the next offset. If the very next host read is of that next offset, it returns the latched byte even when the source has since changed. Any later read returns the live byte.
- R6: Status bits are: 7 TX-disable pin, 6 soft TX disable, 5 secondary rate pin, 4 rate-select pin, 3 soft rate select, 2 TX-fault pin, 1 RX loss-of-signal pin, 0 not-ready. A pin change is visible in bits 7, 5, 4, 2 and 1 within SAMPLE_PERIOD+3 clock cycles.
- R7: Writing offset 110 sets soft TX disable from bit 6. `laser_off` is the OR of that bit and the synchronized TX-disable pin, and the bit clears on reset.
- R8: Writing offset 110 sets soft rate select from bit 3. `rate_full` is the OR of that bit and the synchronized rate-select pin, and the bit clears on reset.
- R9: `not_ready` and status bit 0 stay 1 from reset until the first `meas_valid`, then stay 0 until the next reset.
- R10: Offsets 128..247 are host read/write bytes.
- R11: Host writes to offsets 0..109 and 111..127 have no effect. A write to 110 changes only bits 6 and 3.
- R12: Offsets 106..109, 111..127 and 248..255 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 8 | Host byte offset |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| init_we | input | 1 | Initialization write strobe for offsets 0..94 |
| init_addr | input | 8 | Initialization offset |
| init_wdata | input | 8 | Initialization data |
| meas_valid | input | 1 | New measurement set strobe |
| meas_words | input | 80 | Five 16-bit measurements, temperature in the low word |
| pin_txdis | input | 1 | Asynchronous TX-disable pin |
| pin_rs1 | input | 1 | Asynchronous secondary rate pin |
| pin_rate | input | 1 | Asynchronous rate-select pin |
| pin_txfault | input | 1 | Asynchronous TX-fault pin |
| pin_rxlos | input | 1 | Asynchronous RX loss-of-signal pin |
| laser_off | output | 1 | Effective laser disable |
| rate_full | output | 1 | Effective full-bandwidth select |
| not_ready | output | 1 | Data-not-ready flag |

## Verification
The bench reads a measurement high byte, replaces the measurement, and then reads the low byte. It does the same with a threshold pair and the initialization port. A bank without the pair latch would return a torn value mixing old and new halves. The checksum is checked after a full load and again after one byte is rewritten: a design that only adds new bytes, instead of swapping the old byte for the new one, reports a wrong sum on the rewrite. The bench also writes all ones to the status byte and writes to read-only and unimplemented offsets. A design that decodes write data too broadly would change pin bits, not-ready or measurements, or return nonzero data from empty offsets. A mid-run reset with both soft bits set must clear them and return the laser output to the pin.

// File: rtl/xdiag_pkg.sv
// Shared constants and types for the transceiver diagnostic register bank.
// Assumes an 8-bit offset space; offsets that neighbours decode are fixed here.
package xdiag_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 8;
    localparam int CAL_DEPTH  = 95;    // bytes 0..94 under the checksum
    localparam int THR_LAST   = 39;    // last threshold byte
    localparam int CSUM_ADDR  = 95;
    localparam int MEAS_BASE  = 96;
    localparam int MEAS_WORDS = 5;
    localparam int MEAS_W     = 16;
    localparam int STAT_ADDR  = 110;
    localparam int USER_FIRST = 128;
    localparam int USER_LAST  = 247;
    localparam int MEAS_LAST  = MEAS_BASE + 2 * MEAS_WORDS - 1;

    // Status byte bit positions
    localparam int ST_TXDIS  = 7;
    localparam int ST_SOFTTX = 6;
    localparam int ST_RS1    = 5;
    localparam int ST_RATE   = 4;
    localparam int ST_SOFTRS = 3;
    localparam int ST_FAULT  = 2;
    localparam int ST_LOS    = 1;
    localparam int ST_NRDY   = 0;

    typedef struct packed {
        logic txdis;
        logic rs1;
        logic rate;
        logic txfault;
        logic rxlos;
    } pins_t;
endpackage

// File: rtl/xdiag_sync.sv
// Two-flop synchronizer bank for asynchronous module pins.
// Assumes each bit is independent; no multi-bit coherency is implied.
module xdiag_sync #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic stage1, stage2;
        // Two-stage metastability filter for one pin
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage1 <= 1'b0;
                stage2 <= 1'b0;
            end else begin
                stage1 <= async_in[g];
                stage2 <= stage1;
            end
        end
        assign sync_out[g] = stage2;
    end
endmodule

// File: rtl/xdiag_cal_store.sv
// Threshold/calibration byte store with a running checksum.
// Loaded only through the initialization port; two read ports serve the
// host byte and its pair companion. The checksum is kept by replacing the
// old byte's contribution with the new one on each write.
module xdiag_cal_store #(
    parameter int DEPTH  = 95,
    parameter int ADDR_W = 8,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_we,
    input  logic [ADDR_W-1:0] init_addr,
    input  logic [BYTE_W-1:0] init_wdata,
    input  logic [ADDR_W-1:0] rd_addr_a,
    output logic [BYTE_W-1:0] rd_data_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    output logic [BYTE_W-1:0] rd_data_b,
    output logic [BYTE_W-1:0] csum
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  wr_idx, idx_a, idx_b;
    logic              wr_hit;

    assign wr_idx = IDX_W'(init_addr);
    assign idx_a  = IDX_W'(rd_addr_a);
    assign idx_b  = IDX_W'(rd_addr_b);
    assign wr_hit = init_we && (init_addr < ADDR_W'(DEPTH));

    // Store bytes and keep the checksum current
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            csum <= '0;
        end else if (wr_hit) begin
            mem[wr_idx] <= init_wdata;
            csum        <= csum - mem[wr_idx] + init_wdata;
        end
    end

    // Guarded read ports
    always_comb begin
        rd_data_a = (rd_addr_a < ADDR_W'(DEPTH)) ? mem[idx_a] : '0;
        rd_data_b = (rd_addr_b < ADDR_W'(DEPTH)) ? mem[idx_b] : '0;
    end

    AST_CSUM_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !init_we |=> $stable(csum)); // R3
endmodule

// File: rtl/xdiag_user_mem.sv
// Host read/write scratch area over a contiguous offset window.
// Writes outside the window are dropped; reads outside it return zero.
module xdiag_user_mem #(
    parameter int FIRST  = 128,
    parameter int LAST   = 247,
    parameter int ADDR_W = 8,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int DEPTH = LAST - FIRST + 1;
    localparam int IDX_W = $clog2(DEPTH);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  idx;
    logic              in_win;

    assign in_win = (host_addr >= ADDR_W'(FIRST)) && (host_addr <= ADDR_W'(LAST));
    assign idx    = IDX_W'(host_addr - ADDR_W'(FIRST));

    // Host write into the window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (host_we && in_win) begin
            mem[idx] <= host_wdata;
        end
    end

    // Window read
    assign rd_data = in_win ? mem[idx] : '0;

    AST_USER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        host_we && in_win |=> mem[$past(idx)] == $past(host_wdata)); // R10
endmodule

// File: rtl/xdiag_status.sv
// Status/control byte: periodic pin sampling, soft control bits, not-ready flag.
// Assumes pins arrive already synchronized. Effective outputs use the
// synchronized pins directly so they do not wait for the sample period.
module xdiag_status
    import xdiag_pkg::*;
#(
    parameter int SAMPLE_PERIOD = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  pins_t      pins_sync,
    input  logic       stat_we,
    input  logic       soft_tx_in,
    input  logic       soft_rate_in,
    input  logic       meas_valid,
    output logic [7:0] status_byte,
    output logic       laser_off,
    output logic       rate_full,
    output logic       not_ready
);
    localparam int CNT_W = (SAMPLE_PERIOD > 1) ? $clog2(SAMPLE_PERIOD) : 1;

    logic [CNT_W-1:0] cnt;
    logic             tick;
    pins_t            sampled;
    logic             soft_tx, soft_rate;

    assign tick = (cnt == CNT_W'(SAMPLE_PERIOD - 1));

    // Free-running sample period counter
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (tick)  cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end

    // Capture synchronized pin states once per period
    always_ff @(posedge clk) begin
        if (!rst_n)     sampled <= '0;
        else if (tick)  sampled <= pins_sync;
    end

    // Soft control bits written by the host
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soft_tx   <= 1'b0;
            soft_rate <= 1'b0;
        end else if (stat_we) begin
            soft_tx   <= soft_tx_in;
            soft_rate <= soft_rate_in;
        end
    end

    // Not-ready flag, cleared by the first measurement set
    always_ff @(posedge clk) begin
        if (!rst_n)          not_ready <= 1'b1;
        else if (meas_valid) not_ready <= 1'b0;
    end

    always_comb begin
        status_byte           = '0;
        status_byte[ST_TXDIS]  = sampled.txdis;
        status_byte[ST_SOFTTX] = soft_tx;
        status_byte[ST_RS1]    = sampled.rs1;
        status_byte[ST_RATE]   = sampled.rate;
        status_byte[ST_SOFTRS] = soft_rate;
        status_byte[ST_FAULT]  = sampled.txfault;
        status_byte[ST_LOS]    = sampled.rxlos;
        status_byte[ST_NRDY]   = not_ready;
    end

    assign laser_off = soft_tx   | pins_sync.txdis;
    assign rate_full = soft_rate | pins_sync.rate;

    AST_PIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sampled)); // R6
    AST_NRDY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        !not_ready |=> !not_ready); // R9
    AST_SOFT_TX: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we && soft_tx_in |=> laser_off); // R7
    AST_SOFT_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_we && soft_rate_in |=> rate_full); // R8
endmodule

// File: rtl/xdiag_bank.sv
// Top of the transceiver diagnostic register bank.
// Decodes the host offset space, snapshots measurements, and keeps pair
// reads coherent by latching the low byte when its high byte is read.
// Assumes one host access per strobe and read data taken one cycle later.
module xdiag_bank
    import xdiag_pkg::*;
#(
    parameter int SAMPLE_PERIOD = 1024
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          host_addr,
    input  logic                       host_rd,
    input  logic                       host_wr,
    input  logic [BYTE_W-1:0]          host_wdata,
    output logic [BYTE_W-1:0]          host_rdata,
    input  logic                       init_we,
    input  logic [ADDR_W-1:0]          init_addr,
    input  logic [BYTE_W-1:0]          init_wdata,
    input  logic                       meas_valid,
    input  logic [MEAS_WORDS*MEAS_W-1:0] meas_words,
    input  logic                       pin_txdis,
    input  logic                       pin_rs1,
    input  logic                       pin_rate,
    input  logic                       pin_txfault,
    input  logic                       pin_rxlos,
    output logic                       laser_off,
    output logic                       rate_full,
    output logic                       not_ready
);
    localparam int NPINS = $bits(pins_t);

    pins_t               pins_async, pins_sync;
    logic [NPINS-1:0]    sync_vec;
    logic [BYTE_W-1:0]   cal_a, cal_b, csum, user_rd, status_byte;
    logic [MEAS_W-1:0]   meas_q [MEAS_WORDS];
    logic [2:0]          meas_k;
    logic [ADDR_W-1:0]   next_addr;
    logic                in_cal, in_meas, is_pair_msb, implemented;
    logic [BYTE_W-1:0]   live_byte, comp_byte;
    logic                hold_vld;
    logic [ADDR_W-1:0]   hold_addr;
    logic [BYTE_W-1:0]   hold_byte;

    assign pins_async = '{txdis: pin_txdis, rs1: pin_rs1, rate: pin_rate,
                          txfault: pin_txfault, rxlos: pin_rxlos};

    xdiag_sync #(.WIDTH(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pins_async), .sync_out(sync_vec)
    );
    assign pins_sync = pins_t'(sync_vec);

    xdiag_status #(.SAMPLE_PERIOD(SAMPLE_PERIOD)) u_status (
        .clk(clk), .rst_n(rst_n), .pins_sync(pins_sync),
        .stat_we(host_wr && (host_addr == ADDR_W'(STAT_ADDR))),
        .soft_tx_in(host_wdata[ST_SOFTTX]), .soft_rate_in(host_wdata[ST_SOFTRS]),
        .meas_valid(meas_valid), .status_byte(status_byte),
        .laser_off(laser_off), .rate_full(rate_full), .not_ready(not_ready)
    );

    assign next_addr = host_addr + 1'b1;

    xdiag_cal_store #(.DEPTH(CAL_DEPTH), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_cal (
        .clk(clk), .rst_n(rst_n), .init_we(init_we), .init_addr(init_addr),
        .init_wdata(init_wdata), .rd_addr_a(host_addr), .rd_data_a(cal_a),
        .rd_addr_b(next_addr), .rd_data_b(cal_b), .csum(csum)
    );

    xdiag_user_mem #(.FIRST(USER_FIRST), .LAST(USER_LAST), .ADDR_W(ADDR_W),
                     .BYTE_W(BYTE_W)) u_user (
        .clk(clk), .rst_n(rst_n), .host_we(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .rd_data(user_rd)
    );

    // Snapshot the measurement set on each valid strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < MEAS_WORDS; k++) meas_q[k] <= '0;
        end else if (meas_valid) begin
            for (int k = 0; k < MEAS_WORDS; k++) meas_q[k] <= meas_words[k*MEAS_W +: MEAS_W];
        end
    end

    assign in_cal      = host_addr < ADDR_W'(CAL_DEPTH);
    assign in_meas     = (host_addr >= ADDR_W'(MEAS_BASE)) && (host_addr <= ADDR_W'(MEAS_LAST));
    assign meas_k      = 3'((host_addr - ADDR_W'(MEAS_BASE)) >> 1);
    assign is_pair_msb = !host_addr[0] &&
                         ((host_addr < ADDR_W'(THR_LAST)) || in_meas);
    assign implemented = (host_addr <= ADDR_W'(MEAS_LAST)) ||
                         (host_addr == ADDR_W'(STAT_ADDR)) ||
                         ((host_addr >= ADDR_W'(USER_FIRST)) && (host_addr <= ADDR_W'(USER_LAST)));

    // Live byte at the host offset
    always_comb begin
        live_byte = '0;
        if (in_cal)                                    live_byte = cal_a;
        else if (host_addr == ADDR_W'(CSUM_ADDR))      live_byte = csum;
        else if (in_meas)                              live_byte = host_addr[0] ? meas_q[meas_k][7:0]
                                                                                : meas_q[meas_k][15:8];
        else if (host_addr == ADDR_W'(STAT_ADDR))      live_byte = status_byte;
        else                                           live_byte = user_rd;
    end

    // Companion low byte of a pair whose high byte is being read
    always_comb begin
        comp_byte = in_meas ? meas_q[meas_k][7:0] : cal_b;
    end

    // Registered read data with the pair-coherency latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
            hold_vld   <= 1'b0;
            hold_addr  <= '0;
            hold_byte  <= '0;
        end else if (host_rd) begin
            host_rdata <= (hold_vld && (host_addr == hold_addr)) ? hold_byte : live_byte;
            hold_vld   <= is_pair_msb;
            if (is_pair_msb) begin
                hold_addr <= next_addr;
                hold_byte <= comp_byte;
            end
        end
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata)); // R2
    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && !implemented |=> host_rdata == '0); // R12
    AST_LATCH_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && !is_pair_msb |=> !hold_vld); // R5
endmodule

// File: tb/xdiag_bank_tb.sv
module xdiag_bank_tb;
    localparam int SP = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_addr = '0, host_wdata = '0, init_addr = '0, init_wdata = '0;
    logic        host_rd = 1'b0, host_wr = 1'b0, init_we = 1'b0, meas_valid = 1'b0;
    logic [79:0] meas_words = '0;
    logic        pin_txdis = 0, pin_rs1 = 0, pin_rate = 0, pin_txfault = 0, pin_rxlos = 0;
    logic [7:0]  host_rdata;
    logic        laser_off, rate_full, not_ready;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [95];

    always #10 clk = ~clk;

    xdiag_bank #(.SAMPLE_PERIOD(SP)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .init_we(init_we), .init_addr(init_addr), .init_wdata(init_wdata),
        .meas_valid(meas_valid), .meas_words(meas_words),
        .pin_txdis(pin_txdis), .pin_rs1(pin_rs1), .pin_rate(pin_rate),
        .pin_txfault(pin_txfault), .pin_rxlos(pin_rxlos),
        .laser_off(laser_off), .rate_full(rate_full), .not_ready(not_ready)
    );

    // is_rd, addr, data (write data or expected read)
    localparam logic [16:0] VEC [20] = '{
        {1'b0, 8'd128, 8'hA5}, {1'b1, 8'd128, 8'hA5},   // R10
        {1'b0, 8'd247, 8'h3C}, {1'b1, 8'd247, 8'h3C},   // R10 top edge
        {1'b0, 8'd200, 8'h77}, {1'b1, 8'd200, 8'h77},   // R10
        {1'b1, 8'd127, 8'h00}, {1'b1, 8'd106, 8'h00},   // R12
        {1'b1, 8'd248, 8'h00}, {1'b1, 8'd255, 8'h00},   // R12
        {1'b0, 8'd106, 8'hFF}, {1'b1, 8'd106, 8'h00},   // R11 / R12
        {1'b0, 8'd5,   8'hEE}, {1'b1, 8'd5,   8'h26},   // R11 init value kept
        {1'b0, 8'd110, 8'hFF}, {1'b1, 8'd110, 8'h48},   // R11 only bits 6,3
        {1'b0, 8'd110, 8'h00}, {1'b1, 8'd110, 8'h00},   // R7 R8 clear
        {1'b1, 8'd128, 8'hA5}, {1'b1, 8'd200, 8'h77}    // R10 retained
    };

    function automatic logic [7:0] pat(int i);
        return 8'((i * 7 + 3) & 255);
    endfunction

    function automatic logic [7:0] model_sum();
        logic [7:0] s = '0;
        for (int i = 0; i < 95; i++) s = s + model[i];
        return s;
    endfunction

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic host_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); host_addr = a; host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0; d = host_rdata;
    endtask

    task automatic host_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic init_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); init_addr = a; init_wdata = d; init_we = 1'b1;
        @(negedge clk); init_we = 1'b0;
        model[a] = d;
    endtask

    task automatic load_meas(input logic [79:0] w);
        @(negedge clk); meas_words = w; meas_valid = 1'b1;
        @(negedge clk); meas_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [79:0] m1, m2;
        for (int i = 0; i < 95; i++) model[i] = '0;
        do_reset();

        // R1 reset state
        host_read(8'd110, d); check("R1 status", d, 8'h01);
        host_read(8'd95, d);  check("R1 checksum", d, 8'h00);
        host_read(8'd96, d);  check("R1 meas", d, 8'h00);
        check("R1 not_ready", {7'd0, not_ready}, 8'h01);
        check("R1 laser_off", {7'd0, laser_off}, 8'h00);
        check("R1 rate_full", {7'd0, rate_full}, 8'h00);

        // R2 / R3 initialization load
        for (int i = 0; i < 95; i++) init_write(8'(i), pat(i));
        host_read(8'd0, d);  check("R2 byte0", d, pat(0));
        host_read(8'd14, d); check("R2 supply low-warn msb", d, pat(14));
        host_read(8'd39, d); check("R2 byte39", d, pat(39));
        host_read(8'd94, d); check("R2 byte94", d, pat(94));
        host_read(8'd95, d); check("R3 checksum full", d, model_sum());
        init_write(8'd10, 8'hFF);
        host_read(8'd95, d); check("R3 checksum rewrite", d, model_sum());

        // R9 still not ready before measurements
        check("R9 before meas", {7'd0, not_ready}, 8'h01);

        // R4 measurement capture
        m1 = {16'h0F1E, 16'hDEF0, 16'h9ABC, 16'h5678, 16'h1234};
        load_meas(m1);
        check("R9 cleared", {7'd0, not_ready}, 8'h00);
        for (int k = 0; k < 5; k++) begin
            host_read(8'(96 + 2 * k), d); check("R4 meas msb", d, m1[16*k+8 +: 8]);
            host_read(8'(97 + 2 * k), d); check("R4 meas lsb", d, m1[16*k +: 8]);
        end

        // R5 coherent pair across a measurement update
        m2 = {16'h1111, 16'h2222, 16'h3333, 16'hAAAA, 16'h4444};
        host_read(8'd98, d); check("R5 msb", d, 8'h56);
        load_meas(m2);
        host_read(8'd99, d); check("R5 latched lsb", d, 8'h78);
        host_read(8'd99, d); check("R5 live lsb", d, 8'hAA);
        check("R9 stays low", {7'd0, not_ready}, 8'h00);

        // R5 coherent threshold pair across an init write
        host_read(8'd14, d); check("R5 thr msb", d, pat(14));
        init_write(8'd15, 8'hC3);
        host_read(8'd15, d); check("R5 thr latched", d, pat(15));
        host_read(8'd15, d); check("R5 thr live", d, 8'hC3);

        // R11 host write to measurement is ignored
        host_write(8'd96, 8'hFF);
        host_read(8'd96, d); check("R11 meas write", d, 8'h44);
        host_write(8'd95, 8'h00);
        host_read(8'd95, d); check("R11 checksum write", d, model_sum());

        // Vector table
        foreach (VEC[i]) begin
            if (VEC[i][16]) begin
                host_read(VEC[i][15:8], d);
                check($sformatf("vector %0d", i), d, VEC[i][7:0]);
            end else begin
                host_write(VEC[i][15:8], VEC[i][7:0]);
            end
        end

        // R6 / R7 / R8 pins
        @(negedge clk); pin_txdis = 1'b1;
        repeat (3) @(negedge clk);
        check("R7 pin drives laser_off", {7'd0, laser_off}, 8'h01);
        repeat (SP + 4) @(negedge clk);
        host_read(8'd110, d); check("R6 txdis bit", d, 8'h80);
        @(negedge clk); pin_rs1 = 1; pin_rate = 1; pin_txfault = 1; pin_rxlos = 1;
        repeat (SP + 4) @(negedge clk);
        host_read(8'd110, d); check("R6 all pins", d, 8'hB6);
        check("R8 pin drives rate_full", {7'd0, rate_full}, 8'h01);
        @(negedge clk); pin_txdis = 0; pin_rs1 = 0; pin_rate = 0; pin_txfault = 0; pin_rxlos = 0;
        repeat (SP + 4) @(negedge clk);
        host_read(8'd110, d); check("R6 pins clear", d, 8'h00);

        host_write(8'd110, 8'h40);
        check("R7 soft laser_off", {7'd0, laser_off}, 8'h01);
        check("R8 rate unaffected", {7'd0, rate_full}, 8'h00);
        host_write(8'd110, 8'h08);
        check("R7 soft cleared", {7'd0, laser_off}, 8'h00);
        check("R8 soft rate_full", {7'd0, rate_full}, 8'h01);

        // R7 / R8 / R9 reset clears soft bits, restores not-ready
        host_write(8'd110, 8'h48);
        do_reset();
        @(negedge clk);
        check("R7 reset soft tx", {7'd0, laser_off}, 8'h00);
        check("R8 reset soft rate", {7'd0, rate_full}, 8'h00);
        host_read(8'd110, d); check("R9 reset status", d, 8'h01);

        summary();
        $finish;
    end
endmodule